// File: doc/BRIEF.md
# Embedded Operation Status Byte Generator

This block forms the byte a host sees when it reads the flash array while an internal program or erase routine is in flight. A separate controller owns the command decoding and the cell timing. It hands this block a handful of level signals: whether a routine is running, which kind it is, bit 7 of the byte being programmed, a time-limit-exceeded flag and the state of the sector-erase accept window. The host polls with single-cycle read requests. While a routine runs, or while a timeout stays flagged, each read returns a status byte. Otherwise the array data passes through untouched.

The status byte carries several flags. Bit 7 is a polling bit: it reads as the complement of the byte being programmed, or 0 during erase. Bit 6 flips on every status read. Bit 5 flags a timeout. Bit 4 gives the operation type, and bit 3 shows whether the erase has left its accept window. Software tells that a routine is still running by seeing bit 6 change between two reads. It tells that the routine has finished by seeing bit 7 match the data, which is all ones after an erase.

Reads travel as a valid-only stream. A request pulse on `rd_req` is always accepted, and the answer appears on `rsp_data` with `rsp_valid` exactly one cycle later. There is no back-pressure: the consumer must take every response in the cycle it is offered. `rsp_data` holds its last value between responses.

Top module: `esf_status_gen`

## Requirements
- R1: Out of reset, `rsp_valid` is 0, `rsp_data` is all zeros and the toggle bit is 0, so the first status read returns bit 6 = 0.
- R2: When `busy` and `timeout` are both 0, a read returns `array_data` unchanged.
- R3: When `busy` or `timeout` is 1 and `op_is_erase` is 0 (programming), bit 7 of the response is the inverse of `prog_bit7`.
- R4: When `busy` or `timeout` is 1 and `op_is_erase` is 1, bit 7 of the response is 0.
- R5: In status mode, bit 6 alternates between consecutive reads. It is forced to 0 for the first read after `busy` rises from 0 to 1.
- R6: The toggle bit changes only on a read taken in status mode; idle cycles and pass-through reads leave it unchanged.
- R7: Bit 5 of a status response equals `timeout`.
- R8: Bit 4 of a status response equals `op_is_erase` (0 for programming, 1 for erase).
- R9: Bit 3 of a status response is 1 only during erase with `erase_win_open` at 0, and is 0 otherwise.
- R10: Bits 2 down to 0 of a status response, and every bit above bit 7, read 0.
- R11: `rsp_valid` is 1 in exactly the cycle after each `rd_req` cycle and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| busy | input | 1 | Internal program or erase routine running |
| op_is_erase | input | 1 | Running routine is an erase (1) or a program (0) |
| prog_bit7 | input | 1 | Bit 7 of the byte being programmed |
| timeout | input | 1 | Routine exceeded its time limit; held until the reset command |
| erase_win_open | input | 1 | Sector-erase accept window still open |
| rd_req | input | 1 | Read request, one cycle per read, always accepted |
| array_data | input | DATA_W | Data read from the array |
| rsp_valid | output | 1 | Response valid, one cycle after `rd_req` |
| rsp_data | output | DATA_W | Status byte or array data |

## Verification
The hardest state to reach is a toggle bit whose value depends on history. It has to be known across the start of a new operation, across a timeout that is not busy, and after stretches of idle cycles. The bench sweeps every combination of the five control inputs against several array patterns. Before each combination it drops `busy` for one cycle so that a fresh operation start occurs, then issues three reads separated by varying idle gaps. A model of the toggle bit, updated only on status reads and cleared on each rise of `busy`, predicts bit 6 for every read.

// File: rtl/esf_pkg.sv
package esf_pkg;
  // Bit positions of the status flags; the host decodes these positions.
  localparam int unsigned POLL_BIT = 7;
  localparam int unsigned TGL_BIT  = 6;
  localparam int unsigned TMO_BIT  = 5;
  localparam int unsigned KIND_BIT = 4;
  localparam int unsigned WIN_BIT  = 3;
  localparam int unsigned STAT_W   = 8;

  typedef struct packed {
    logic busy;
    logic erase;
    logic pbit7;
    logic tmo;
    logic win_open;
  } op_ctl_t;
endpackage

// File: rtl/esf_toggle.sv
module esf_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic rd_fire,
  output logic tgl_eff
);
  logic busy_q;
  logic tgl_q;
  logic start;

  assign start   = busy & ~busy_q;
  assign tgl_eff = start ? 1'b0 : tgl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tgl_q  <= 1'b0;
    end else begin
      busy_q <= busy;
      tgl_q  <= tgl_eff ^ rd_fire;
    end
  end

  AST_TGL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_fire && !start) |=> (tgl_q == $past(tgl_q))); // R6
  AST_TGL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !start) |=> (tgl_q != $past(tgl_q))); // R5
  AST_TGL_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (tgl_q == $past(rd_fire))); // R5
endmodule

// File: rtl/esf_compose.sv
module esf_compose
  import esf_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  op_ctl_t           ctl,
  input  logic              tgl,
  input  logic [DATA_W-1:0] array_data,
  output logic              status_mode,
  output logic [DATA_W-1:0] out_data
);
  logic [STAT_W-1:0] stat;

  assign status_mode = ctl.busy | ctl.tmo;

  always_comb begin
    stat           = '0;
    stat[POLL_BIT] = ctl.erase ? 1'b0 : ~ctl.pbit7;
    stat[TGL_BIT]  = tgl;
    stat[TMO_BIT]  = ctl.tmo;
    stat[KIND_BIT] = ctl.erase;
    stat[WIN_BIT]  = ctl.erase & ~ctl.win_open;
  end

  generate
    if (DATA_W > STAT_W) begin : g_wide
      assign out_data = status_mode ? {{(DATA_W-STAT_W){1'b0}}, stat} : array_data;
    end else begin : g_byte
      assign out_data = status_mode ? stat[DATA_W-1:0] : array_data;
    end
  endgenerate
endmodule

// File: rtl/esf_rsp_reg.sv
module esf_rsp_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [DATA_W-1:0] in_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_data <= in_data;
    end
  end

  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid); // R11
  AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_valid); // R11
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(rsp_data)); // R11
endmodule

// File: rtl/esf_status_gen.sv
module esf_status_gen
  import esf_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              op_is_erase,
  input  logic              prog_bit7,
  input  logic              timeout,
  input  logic              erase_win_open,
  input  logic              rd_req,
  input  logic [DATA_W-1:0] array_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  op_ctl_t           ctl;
  logic              tgl;
  logic              status_mode;
  logic [DATA_W-1:0] out_data;

  assign ctl = '{busy: busy, erase: op_is_erase, pbit7: prog_bit7,
                 tmo: timeout, win_open: erase_win_open};

  esf_toggle u_toggle (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .rd_fire (rd_req & status_mode),
    .tgl_eff (tgl)
  );

  esf_compose #(.DATA_W(DATA_W)) u_compose (
    .ctl         (ctl),
    .tgl         (tgl),
    .array_data  (array_data),
    .status_mode (status_mode),
    .out_data    (out_data)
  );

  esf_rsp_reg #(.DATA_W(DATA_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .in_data   (out_data),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  initial begin
    AST_WIDTH_OK: assert (DATA_W >= STAT_W); // R10
  end

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !busy && !timeout) |=> (rsp_data == $past(array_data))); // R2
  AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && (busy || timeout) && !op_is_erase) |=> (rsp_data[POLL_BIT] == !$past(prog_bit7))); // R3
  AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && (busy || timeout) && op_is_erase) |=> !rsp_data[POLL_BIT]); // R4
  AST_TMO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && (busy || timeout)) |=> (rsp_data[TMO_BIT] == $past(timeout))); // R7
  AST_KIND_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && (busy || timeout)) |=> (rsp_data[KIND_BIT] == $past(op_is_erase))); // R8
  AST_WIN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && (busy || timeout)) |=> (rsp_data[WIN_BIT] == $past(op_is_erase && !erase_win_open))); // R9
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && (busy || timeout)) |=> (rsp_data[2:0] == 3'b000)); // R10
endmodule

// File: tb/esf_status_gen_bench.sv
module esf_status_gen_bench;
  localparam int unsigned DATA_W = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned WATCHDOG = 20000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              busy = 1'b0;
  logic              op_is_erase = 1'b0;
  logic              prog_bit7 = 1'b0;
  logic              timeout = 1'b0;
  logic              erase_win_open = 1'b0;
  logic              rd_req = 1'b0;
  logic [DATA_W-1:0] array_data = '0;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic m_tgl = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  esf_status_gen #(.DATA_W(DATA_W)) u_esf_status_gen (
    .clk(clk), .rst_n(rst_n), .busy(busy), .op_is_erase(op_is_erase),
    .prog_bit7(prog_bit7), .timeout(timeout), .erase_win_open(erase_win_open),
    .rd_req(rd_req), .array_data(array_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected response built from the requirement text.
  function automatic logic [DATA_W-1:0] expect_byte();
    logic [DATA_W-1:0] e;
    if (!busy && !timeout) return array_data;          // R2
    e = '0;                                            // R10
    e[7] = op_is_erase ? 1'b0 : !prog_bit7;            // R3 R4
    e[6] = m_tgl;                                      // R5
    e[5] = timeout;                                    // R7
    e[4] = op_is_erase;                                // R8
    e[3] = op_is_erase && !erase_win_open;             // R9
    return e;
  endfunction

  task automatic do_read(input int gap);
    logic [DATA_W-1:0] exp;
    logic stat;
    exp  = expect_byte();
    stat = busy || timeout;
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    check("R11 valid after read", 32'(rsp_valid), 32'd1);
    check("R2-R10 response byte", 32'(rsp_data), 32'(exp));
    if (stat) m_tgl = !m_tgl;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      check("R11 valid idle", 32'(rsp_valid), 32'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", 32'(rsp_valid), 32'd0);
    check("R1 reset data", 32'(rsp_data), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: toggle starts at 0; timeout without busy edge keeps reset value.
    timeout = 1'b1;
    do_read(0);
    timeout = 1'b0;
    @(negedge clk);
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 32; c++) begin
        busy = 1'b0; timeout = 1'b0;
        @(negedge clk);
        array_data     = DATA_W'((p == 0) ? 8'h00 : (p == 1) ? 8'hFF : (p == 2) ? 8'hA5 : 8'h3C) ^ DATA_W'(c);
        busy           = c[0];
        op_is_erase    = c[1];
        prog_bit7      = c[2];
        timeout        = c[3];
        erase_win_open = c[4];
        if (busy) m_tgl = 1'b0;                        // R5 cleared at start
        @(negedge clk);
        // R6: gaps of varying length between reads keep the toggle steady.
        for (int r = 0; r < 3; r++) do_read((c + r) % 3);
      end
    end
    busy = 1'b0; timeout = 1'b0;
    array_data = 8'h5A;
    @(negedge clk);
    do_read(1);                                        // R2 after completion
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int n = 0; n < WATCHDOG; n++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule